// File: doc/BRIEF.md
# Chip-Select Matcher with Spare-Rank Redirect

This block resolves which rank of a memory channel holds a given normalized channel address. It receives the address, the channel it was steered to, a gang flag, and each channel's rank configuration: eight base registers, four mask registers and one spare-control word. Each base register carries an enable bit and a spare-rank flag. An enabled rank claims the address when the address and the base agree on every register field bit that the rank's mask does not cover. Two neighbouring ranks share each mask register.

Ranks are searched in ascending order, and the lowest one that claims the address wins. If the spare-control word reports that the selected channel has already swapped out a failed rank, and the winner is that failed rank, the result moves to the lowest rank flagged as spare. If no rank is flagged as spare, the winner is kept. In gang mode both channels act as one, so the rank configuration of channel 0 is always used. The result is registered one clock after the inputs are presented. It gives a found flag, the rank number and the DIMM number.

Top module: `chip_select_matcher`

## Requirements
- R1: Base register bit 0 enables a rank. An enabled rank matches when `(chanAddr >> 8) & FIELD_MASK & ~mask` equals `base & FIELD_MASK & ~mask`. The low 8 address bits never affect the result.
- R2: Rank n is compared using mask register n/2, so ranks 2k and 2k+1 share mask k.
- R3: A rank whose enable bit is 0 never matches, even if its base and mask would claim the address.
- R4: When several enabled ranks match, the lowest-numbered one is reported.
- R5: For channel c, the swap-done flag is `spareCtl[1+2c]` and the failed rank is `spareCtl[4+4c +: 3]`. When swap-done is 1 and the matched rank equals the failed rank, the output rank becomes the lowest rank whose base bit 1 (spare flag) is set.
- R6: With swap-done 0, or with a matched rank different from the failed rank, the matched rank is reported unchanged. The spare-control fields of the other channel are ignored.
- R7: With `gangMode` 1, channel 0's base and mask registers are used whatever `chanSel` is. The swap-done flag and failed-rank field are still taken for `chanSel`.
- R8: `dimmOut` equals the reported rank divided by 2.
- R9: When no rank matches, `found` is 0 and both `csOut` and `dimmOut` are 0.
- R10: Outputs update on the clock edge after the inputs are applied. An active-low `rstN` clears `found`, `csOut` and `dimmOut` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanAddr | input | 40 | Normalized channel address |
| chanSel | input | 1 | Selected channel |
| gangMode | input | 1 | Both channels ganged; use channel 0 registers |
| csBaseFlat | input | 512 | Base registers, rank r of channel c at bits [(c*8+r)*32 +: 32] |
| csMaskFlat | input | 256 | Mask registers, mask k of channel c at bits [(c*4+k)*32 +: 32] |
| spareCtl | input | 12 | Spare-control word: swap-done and failed-rank fields per channel |
| csOut | output | 3 | Reported rank |
| dimmOut | output | 2 | DIMM number (rank / 2) |
| found | output | 1 | Some enabled rank matched |

## Verification
The two channels are programmed so that an address lands in ranks that overlap. In one case a small rank lies inside a larger one that uses a different shared mask. In another, a disabled rank would otherwise claim the address. These cases separate the lowest-wins rule from the enable rule and confirm that masks are paired. Spare-control words are applied with only swap-done set, with only a failed-rank field set, with both set, and with the fields of the other channel set. This shows that redirection needs both conditions and reads the field positions of the selected channel. Gang-mode vectors choose channel 1 while channel 0 is programmed differently. This shows which register set and which spare fields are used. Addresses outside every rank check the zeroed miss result.

// File: rtl/csm_pkg.sv
package csm_pkg;
  parameter int CsCount = 8;
  localparam int CsIdxW = $clog2(CsCount);
  localparam int MaskCount = CsCount / 2;

  typedef struct packed {
    logic                hit;
    logic                redirect;
    logic [CsIdxW-1:0]   hitIdx;
    logic [CsIdxW-1:0]   spareIdx;
  } csm_strobe_t;
endpackage

// File: rtl/csm_ctrl.sv
module csm_ctrl
  import csm_pkg::*;
#(
  parameter int NUM_CH  = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SPARE_W = 4 + 4 * NUM_CH
) (
  input  logic [CsCount-1:0] matchVec,
  input  logic [CsCount-1:0] spareVec,
  input  logic [CH_W-1:0]    chanSel,
  input  logic [SPARE_W-1:0] spareCtl,
  output csm_strobe_t        strobes
);
  logic [CsIdxW-1:0] firstHit;
  logic [CsIdxW-1:0] firstSpare;
  logic              anySpare;
  logic              swapDone;
  logic [2:0]        failedCs;

  // Lowest-index encoders: walk downward so the smallest index is assigned last.
  always_comb begin
    firstHit   = '0;
    firstSpare = '0;
    anySpare   = 1'b0;
    for (int i = CsCount - 1; i >= 0; i--) begin
      if (matchVec[i]) firstHit = CsIdxW'(i);
      if (spareVec[i]) begin
        firstSpare = CsIdxW'(i);
        anySpare   = 1'b1;
      end
    end
  end

  // Per-channel swap status fields; positions are fixed by the control-word layout.
  always_comb begin
    swapDone = spareCtl[1 + 2 * chanSel];
    failedCs = spareCtl[4 + 4 * chanSel +: 3];
  end

  always_comb begin
    strobes.hit      = |matchVec;
    strobes.hitIdx   = firstHit;
    strobes.spareIdx = firstSpare;
    strobes.redirect = strobes.hit && swapDone && anySpare &&
                       (3'(firstHit) == failedCs);
  end
endmodule

// File: rtl/csm_datapath.sv
module csm_datapath
  import csm_pkg::*;
#(
  parameter int          NUM_CH     = 2,
  parameter int          ADDR_W     = 40,
  parameter int          REG_W      = 32,
  parameter logic [31:0] FIELD_MASK = 32'h1FFF_FFE0,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BASE_W  = NUM_CH * CsCount * REG_W,
  localparam int MASK_W  = NUM_CH * MaskCount * REG_W,
  localparam int DIMM_W  = CsIdxW - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              gangMode,
  input  logic [BASE_W-1:0] csBaseFlat,
  input  logic [MASK_W-1:0] csMaskFlat,
  input  csm_strobe_t       strobes,
  output logic [CsCount-1:0] matchVec,
  output logic [CsCount-1:0] spareVec,
  output logic [CsIdxW-1:0] csOut,
  output logic [DIMM_W-1:0] dimmOut,
  output logic              found
);
  logic [CH_W-1:0]   effChan;
  logic [REG_W-1:0]  addrField;
  logic [CsIdxW-1:0] nextCs;

  assign effChan   = gangMode ? '0 : chanSel;
  assign addrField = REG_W'(chanAddr >> 8);

  for (genvar g = 0; g < CsCount; g++) begin : g_rank
    logic [REG_W-1:0] baseReg;
    logic [REG_W-1:0] maskReg;
    logic [REG_W-1:0] careBits;
    assign baseReg  = csBaseFlat[(effChan * CsCount + g) * REG_W +: REG_W];
    assign maskReg  = csMaskFlat[(effChan * MaskCount + g / 2) * REG_W +: REG_W];
    assign careBits = REG_W'(FIELD_MASK) & ~maskReg;
    assign matchVec[g] = baseReg[0] && ((addrField & careBits) == (baseReg & careBits));
    assign spareVec[g] = baseReg[1];
  end

  assign nextCs = !strobes.hit    ? '0 :
                  strobes.redirect ? strobes.spareIdx : strobes.hitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      found   <= 1'b0;
      csOut   <= '0;
      dimmOut <= '0;
    end else begin
      found   <= strobes.hit;
      csOut   <= nextCs;
      dimmOut <= nextCs[CsIdxW-1:1];
    end
  end
endmodule

// File: rtl/chip_select_matcher.sv
module chip_select_matcher
  import csm_pkg::*;
#(
  parameter int          NUM_CH     = 2,
  parameter int          ADDR_W     = 40,
  parameter int          REG_W      = 32,
  parameter logic [31:0] FIELD_MASK = 32'h1FFF_FFE0,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BASE_W  = NUM_CH * CsCount * REG_W,
  localparam int MASK_W  = NUM_CH * MaskCount * REG_W,
  localparam int SPARE_W = 4 + 4 * NUM_CH,
  localparam int DIMM_W  = CsIdxW - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  chanAddr,
  input  logic [CH_W-1:0]    chanSel,
  input  logic               gangMode,
  input  logic [BASE_W-1:0]  csBaseFlat,
  input  logic [MASK_W-1:0]  csMaskFlat,
  input  logic [SPARE_W-1:0] spareCtl,
  output logic [CsIdxW-1:0]  csOut,
  output logic [DIMM_W-1:0]  dimmOut,
  output logic               found
);
  csm_strobe_t        strb;
  logic [CsCount-1:0] matchVec;
  logic [CsCount-1:0] spareVec;

  csm_datapath #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REG_W(REG_W), .FIELD_MASK(FIELD_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .chanAddr(chanAddr), .chanSel(chanSel),
    .gangMode(gangMode), .csBaseFlat(csBaseFlat), .csMaskFlat(csMaskFlat),
    .strobes(strb), .matchVec(matchVec), .spareVec(spareVec),
    .csOut(csOut), .dimmOut(dimmOut), .found(found)
  );

  csm_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .matchVec(matchVec), .spareVec(spareVec), .chanSel(chanSel),
    .spareCtl(spareCtl), .strobes(strb)
  );
endmodule

// File: rtl/csm_checker.sv
module csm_checker
  import csm_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [CsCount-1:0] matchVec,
  input logic [CsCount-1:0] spareVec,
  input csm_strobe_t        strobes,
  input logic [CsIdxW-1:0]  csOut,
  input logic [CsIdxW-2:0]  dimmOut,
  input logic               found
);
  p_hit_matches_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hit |-> matchVec[strobes.hitIdx]);

  p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hit |-> ((matchVec & ((CsCount'(1) << strobes.hitIdx) - CsCount'(1))) == '0));

  p_redirect_spare_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.redirect |-> spareVec[strobes.spareIdx]);

  p_dimm_half_r8: assert property (@(posedge clk) disable iff (!rstN)
    dimmOut == csOut[CsIdxW-1:1]);

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !found |-> (csOut == '0 && dimmOut == '0));

  p_found_next_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|matchVec) |=> found);

  p_miss_next_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(|matchVec) |=> !found);
endmodule

bind chip_select_matcher csm_checker u_chk (
  .clk(clk), .rstN(rstN), .matchVec(matchVec), .spareVec(spareVec),
  .strobes(strb), .csOut(csOut), .dimmOut(dimmOut), .found(found)
);

// File: tb/chip_select_matcher_tb.sv
module chip_select_matcher_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [39:0]  chanAddr = '0;
  logic         chanSel = 1'b0;
  logic         gangMode = 1'b0;
  logic [511:0] csBaseFlat = '0;
  logic [255:0] csMaskFlat = '0;
  logic [11:0]  spareCtl = '0;
  logic [2:0]   csOut;
  logic [1:0]   dimmOut;
  logic         found;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  chip_select_matcher u_dut (
    .clk(clk), .rstN(rstN), .chanAddr(chanAddr), .chanSel(chanSel),
    .gangMode(gangMode), .csBaseFlat(csBaseFlat), .csMaskFlat(csMaskFlat),
    .spareCtl(spareCtl), .csOut(csOut), .dimmOut(dimmOut), .found(found)
  );

  typedef struct packed {
    logic [39:0] addr;
    logic        chan;
    logic        gang;
    logic [11:0] spare;
    logic        expFound;
    logic [2:0]  expCs;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{40'h00_0000_1000, 1'b0, 1'b0, 12'h000, 1'b1, 3'd0}, // R1 R4: ranks 0 and 2 overlap
    '{40'h00_1000_0040, 1'b0, 1'b0, 12'h000, 1'b1, 3'd1}, // R2 R4: rank 1 inside rank 2
    '{40'h00_2000_0000, 1'b0, 1'b0, 12'h000, 1'b1, 3'd4}, // R3: disabled rank 3 skipped
    '{40'h00_5000_0000, 1'b0, 1'b0, 12'h000, 1'b1, 3'd7}, // R8: dimm 3
    '{40'h00_9000_0000, 1'b0, 1'b0, 12'h000, 1'b0, 3'd0}, // R9: miss
    '{40'h00_2000_0000, 1'b0, 1'b0, 12'h042, 1'b1, 3'd5}, // R5: channel 0 redirect
    '{40'h00_0000_1000, 1'b0, 1'b0, 12'h042, 1'b1, 3'd0}, // R6: not the failed rank
    '{40'h00_2000_0000, 1'b0, 1'b0, 12'h040, 1'b1, 3'd4}, // R6: swap not done
    '{40'h00_0000_1000, 1'b1, 1'b0, 12'h000, 1'b1, 3'd1}, // R3: channel 1 rank 0 disabled
    '{40'h00_2000_0000, 1'b1, 1'b0, 12'h000, 1'b1, 3'd3}, // R2: channel 1 shared mask
    '{40'h00_2000_0000, 1'b1, 1'b0, 12'h308, 1'b1, 3'd2}, // R5: channel 1 redirect
    '{40'h00_2000_0000, 1'b1, 1'b0, 12'h042, 1'b1, 3'd3}, // R6: other channel fields ignored
    '{40'h00_0000_1000, 1'b1, 1'b1, 12'h000, 1'b1, 3'd0}, // R7: gang uses channel 0
    '{40'h00_2000_0000, 1'b1, 1'b1, 12'h408, 1'b1, 3'd5}, // R7: gang, channel 1 spare field
    '{40'h00_1000_0000, 1'b1, 1'b0, 12'h000, 1'b1, 3'd2}  // R1: enabled spare rank matches
  };
  localparam string TAGS [NV] = '{
    "R1/R4", "R2/R4", "R3", "R8", "R9", "R5", "R6", "R6",
    "R3", "R2", "R5", "R6", "R7", "R7", "R1"
  };

  task automatic setBase(input int ch, input int cs, input logic [31:0] v);
    csBaseFlat[(ch * 8 + cs) * 32 +: 32] = v;
  endtask

  task automatic setMask(input int ch, input int m, input logic [31:0] v);
    csMaskFlat[(ch * 4 + m) * 32 +: 32] = v;
  endtask

  task automatic checkOut(input string tag, input logic expF, input logic [2:0] expC);
    logic [1:0] expD;
    expD = expC[2:1];
    checks++;
    if (found !== expF || csOut !== expC || dimmOut !== expD) begin
      errors++;
      $display("FAIL %s: found=%0b cs=%0d dimm=%0d expected found=%0b cs=%0d dimm=%0d",
               tag, found, csOut, dimmOut, expF, expC, expD);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    chanAddr = v.addr;
    chanSel  = v.chan;
    gangMode = v.gang;
    spareCtl = v.spare;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // Channel 0 ranks
    setBase(0, 0, 32'h0000_0001);
    setBase(0, 1, 32'h0010_0001);
    setBase(0, 2, 32'h0000_0001);
    setBase(0, 3, 32'h0020_0000);
    setBase(0, 4, 32'h0020_0001);
    setBase(0, 5, 32'h0070_0003);
    setBase(0, 6, 32'h0040_0001);
    setBase(0, 7, 32'h0050_0003);
    setMask(0, 0, 32'h000F_FFE0);
    setMask(0, 1, 32'h001F_FFE0);
    setMask(0, 2, 32'h000F_FFE0);
    setMask(0, 3, 32'h000F_FFE0);
    // Channel 1 ranks
    setBase(1, 0, 32'h0000_0000);
    setBase(1, 1, 32'h0000_0001);
    setBase(1, 2, 32'h0010_0003);
    setBase(1, 3, 32'h0020_0001);
    setBase(1, 6, 32'h0000_0002);
    for (int m = 0; m < 4; m++) setMask(1, m, 32'h000F_FFE0);

    chanAddr = 40'h00_0000_1000;
    repeat (3) @(posedge clk);
    #1;
    checkOut("R10 reset", 1'b0, 3'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      checkOut(TAGS[i], VEC[i].expFound, VEC[i].expCs);
    end

    // R1: low 8 address bits have no effect
    apply('{40'h00_5000_00FF, 1'b0, 1'b0, 12'h000, 1'b1, 3'd7});
    checkOut("R1 low bits", 1'b1, 3'd7);

    // R10: one-cycle latency, old result still visible before the edge
    @(negedge clk);
    chanAddr = 40'h00_9000_0000;
    chanSel = 1'b0;
    gangMode = 1'b0;
    spareCtl = '0;
    #1;
    checkOut("R10 latency hold", 1'b1, 3'd7);
    @(posedge clk);
    #1;
    checkOut("R10 latency update", 1'b0, 3'd0);

    // R10: asynchronous reset clears a hit
    apply('{40'h00_5000_0000, 1'b0, 1'b0, 12'h000, 1'b1, 3'd7});
    checkOut("R8 before reset", 1'b1, 3'd7);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R10 async reset", 1'b0, 3'd0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule